// File: doc/BRIEF.md
# 1-Wire Timing Tick Generator

This block divides the system clock down to the roughly 1 MHz timing tick that a 1-Wire bus engine paces its slots with. The division ratio is an odd prescale factor (1, 3, 5 or 7) multiplied by a power of two from 1 to 128. For a system clock of that many MHz, the tick therefore lands on 1 MHz.

All settings come from one 8-bit configuration byte, loaded by a single-cycle write strobe. Bit 7 enables the divider. Bits 1:0 pick the prescale: 00 gives 1, 01 gives 3, 10 gives 5 and 11 gives 7. Bits 4:2 hold the exponent n of the 2^n divide. Bits 6:5 carry no meaning. For example, 0x95 selects 3 × 32 and suits a 96 MHz input.

Every write restarts the counting from zero, so the block can be reprogrammed without a runt or stretched tick. A ready flag tells the host when the first full period at the new setting has completed.

Top module: `onew_tick_gen`

## Requirements
- R1: After reset, tick and ready are 0 and the divider is disabled until a configuration write sets bit 7.
- R2: While bit 7 of the stored configuration is 0, tick stays 0 and ready stays 0, for any value in the other bits.
- R3: Bits 1:0 choose the prescale factor P: 00 selects 1, 01 selects 3, 10 selects 5 and 11 selects 7.
- R4: Bits 4:2 hold the exponent n, which multiplies the ratio by 2^n for n from 0 to 7.
- R5: With the divider enabled, tick repeats every P × 2^n clock cycles.
- R6: When the ratio is greater than 1, each tick is exactly one clock cycle wide.
- R7: A write clears both counters and the tick output. The first tick then appears exactly P × 2^n cycles after the clock edge that accepted the write, including when the write lands in the middle of a period.
- R8: Ready drops to 0 on every write, rises in the same cycle as the first tick after the write, and stays 1 until the next write.
- R9: Bits 6:5 of the configuration byte have no effect on tick timing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_wr | input | 1 | Single-cycle strobe that loads cfg_wdata |
| cfg_wdata | input | 8 | Configuration byte: enable, exponent and prescale fields |
| tick | output | 1 | One-cycle timing pulse, once per divide period |
| ready | output | 1 | High once the first full period after a write has finished |

## Verification
Call the clock edge that samples the write strobe edge 0. The tick output is registered, so the counters cross their joint wrap point after edge P × 2^n − 1 and tick is high after edge P × 2^n. Ready rises after that same edge.

The bench applies each write at a falling edge and counts falling edges after edge 0. The first tick and the ready rise are therefore both expected at count P × 2^n, and the second tick at twice that count. A single-cycle pulse must already be low at one count past each tick.

Disabled settings and writes in the middle of a period are checked by watching the ports over a whole window, with no tick allowed before the newly due count.

// File: rtl/onew_tick_pkg.sv
package onew_tick_pkg;
   // Default field layout of the configuration byte
   localparam int unsigned CFG_W_DEF  = 8;
   localparam int unsigned EN_BIT_DEF = 7;
   localparam int unsigned SEL_W_DEF  = 2;
   localparam int unsigned EXP_W_DEF  = 3;

   // Total divide ratio for a given prescale selector and exponent
   function automatic int unsigned div_ratio(input int unsigned sel, input int unsigned expo);
      return (2 * sel + 1) << expo;
   endfunction
endpackage

// File: rtl/onew_prescale_cnt.sv
module onew_prescale_cnt #(
   parameter int unsigned SEL_W = 2,
   localparam int unsigned CNT_W = SEL_W + 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clr,
   input  logic             run,
   input  logic [SEL_W-1:0] sel,
   output logic             wrap
);
   logic [CNT_W-1:0] cnt_q;
   logic [CNT_W-1:0] last;

   // Odd factor 2*sel+1 counts 0 .. 2*sel
   assign last = {sel, 1'b0};
   assign wrap = run && (cnt_q == last);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
      end else if (clr || !run || wrap) begin
         cnt_q <= '0;
      end else begin
         cnt_q <= cnt_q + 1'b1;
      end
   end
endmodule

// File: rtl/onew_pow2_cnt.sv
module onew_pow2_cnt #(
   parameter int unsigned EXP_W = 3,
   localparam int unsigned CNT_W = (1 << EXP_W) - 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clr,
   input  logic             run,
   input  logic             step,
   input  logic [EXP_W-1:0] expo,
   output logic             wrap
);
   logic [CNT_W-1:0] cnt_q;
   logic [CNT_W-1:0] last;

   // Terminal count 2^expo - 1: low expo bits set, the rest clear
   for (genvar i = 0; i < CNT_W; i++) begin : g_last
      assign last[i] = (i < int'(expo));
   end

   assign wrap = run && (cnt_q == last);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
      end else if (clr || !run) begin
         cnt_q <= '0;
      end else if (step) begin
         if (wrap) begin
            cnt_q <= '0;
         end else begin
            cnt_q <= cnt_q + 1'b1;
         end
      end
   end
endmodule

// File: rtl/onew_tick_gen.sv
module onew_tick_gen
   import onew_tick_pkg::*;
#(
   parameter int unsigned CFG_W  = CFG_W_DEF,
   parameter int unsigned EN_BIT = EN_BIT_DEF,
   parameter int unsigned SEL_W  = SEL_W_DEF,
   parameter int unsigned EXP_W  = EXP_W_DEF
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             cfg_wr,
   input  logic [CFG_W-1:0] cfg_wdata,
   output logic             tick,
   output logic             ready
);
   localparam int unsigned FIELD_W = SEL_W + EXP_W;

   if (EN_BIT >= CFG_W) begin : g_bad_en
      $error("enable bit lies outside the configuration byte");
   end
   if (FIELD_W > EN_BIT) begin : g_bad_fields
      $error("divisor fields overlap the enable bit");
   end
   if (SEL_W < 1 || EXP_W < 1) begin : g_bad_width
      $error("prescale and exponent fields need at least one bit");
   end

   logic [CFG_W-1:0] cfg_q;
   logic             run;
   logic             pre_wrap;
   logic             pow_wrap;
   logic             full_wrap;
   logic             tick_q;
   logic             ready_q;
   logic             unused_cfg_bits;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cfg_q <= '0;
      end else if (cfg_wr) begin
         cfg_q <= cfg_wdata;
      end
   end

   assign run = cfg_q[EN_BIT];
   assign unused_cfg_bits = ^cfg_q;

   onew_prescale_cnt #(.SEL_W(SEL_W)) u_pre (
      .clk  (clk),
      .rst_n(rst_n),
      .clr  (cfg_wr),
      .run  (run),
      .sel  (cfg_q[SEL_W-1:0]),
      .wrap (pre_wrap)
   );

   onew_pow2_cnt #(.EXP_W(EXP_W)) u_pow (
      .clk  (clk),
      .rst_n(rst_n),
      .clr  (cfg_wr),
      .run  (run),
      .step (pre_wrap),
      .expo (cfg_q[SEL_W +: EXP_W]),
      .wrap (pow_wrap)
   );

   assign full_wrap = pre_wrap && pow_wrap && !cfg_wr;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         tick_q  <= 1'b0;
         ready_q <= 1'b0;
      end else begin
         tick_q <= full_wrap;
         if (cfg_wr) begin
            ready_q <= 1'b0;
         end else if (full_wrap) begin
            ready_q <= 1'b1;
         end
      end
   end

   assign tick  = tick_q;
   assign ready = ready_q;
endmodule

// File: rtl/onew_tick_gen_chk.sv
module onew_tick_gen_chk #(
   parameter int unsigned CFG_W  = 8,
   parameter int unsigned EN_BIT = 7,
   parameter int unsigned SEL_W  = 2,
   parameter int unsigned EXP_W  = 3
) (
   input logic             clk,
   input logic             rst_n,
   input logic             cfg_wr,
   input logic [CFG_W-1:0] cfg_q,
   input logic             tick,
   input logic             ready
);
   localparam int unsigned FIELD_W = SEL_W + EXP_W;

   assert_idle_when_off_R2: assert property (@(posedge clk) disable iff (!rst_n)
      !cfg_q[EN_BIT] |-> (!tick && !ready));

   assert_single_cycle_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (tick && (cfg_q[FIELD_W-1:0] != '0)) |=> !tick);

   assert_write_clears_R7: assert property (@(posedge clk) disable iff (!rst_n)
      cfg_wr |=> (!tick && !ready));

   assert_ready_with_tick_R8: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(ready) |-> tick);

   assert_ready_holds_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (ready && !cfg_wr) |=> ready);
endmodule

bind onew_tick_gen onew_tick_gen_chk #(
   .CFG_W (CFG_W),
   .EN_BIT(EN_BIT),
   .SEL_W (SEL_W),
   .EXP_W (EXP_W)
) u_chk (
   .clk   (clk),
   .rst_n (rst_n),
   .cfg_wr(cfg_wr),
   .cfg_q (cfg_q),
   .tick  (tick),
   .ready (ready)
);

// File: tb/onew_tick_gen_tb.sv
module onew_tick_gen_tb;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       cfg_wr = 1'b0;
   logic [7:0] cfg_wdata = 8'h00;
   logic       tick;
   logic       ready;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   always #10 clk = ~clk;

   onew_tick_gen u_dut (
      .clk      (clk),
      .rst_n    (rst_n),
      .cfg_wr   (cfg_wr),
      .cfg_wdata(cfg_wdata),
      .tick     (tick),
      .ready    (ready)
   );

   // {configuration byte, expected ratio}
   localparam int NVEC = 13;
   localparam logic [7:0] VEC_CFG [NVEC] = '{
      8'h80, 8'h81, 8'h82, 8'h83, 8'h84, 8'h88, 8'h8C,
      8'h90, 8'h95, 8'h9C, 8'h9F, 8'hE1, 8'hA2 };
   localparam int VEC_RATIO [NVEC] = '{
      1, 3, 5, 7, 2, 4, 8, 16, 96, 128, 896, 3, 5 };

   task automatic check(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   // Write at a falling edge; returns at the falling edge after the accepting edge
   task automatic write_cfg(input logic [7:0] v);
      @(negedge clk);
      cfg_wr = 1'b1;
      cfg_wdata = v;
      @(negedge clk);
      cfg_wr = 1'b0;
   endtask

   // Count falling edges until tick, up to limit; returns count or -1
   task automatic wait_tick(input int limit, output int k, output bit rdy_early);
      k = -1;
      rdy_early = 1'b0;
      for (int i = 1; i <= limit; i++) begin
         @(negedge clk);
         if (tick) begin
            k = i;
            break;
         end
         if (ready) rdy_early = 1'b1;
      end
   endtask

   task automatic summary();
      $display("CHECKS %0d ERRORS %0d", checks, errors);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL R7 watchdog expired actual=1 expected=0");
         summary();
         $finish;
      end
   end

   initial begin
      int k;
      int k2;
      bit early;
      int seen;

      // R1: reset state
      repeat (3) @(negedge clk);
      check(tick == 1'b0 && ready == 1'b0, "R1 outputs in reset", {tick, ready}, 0);
      rst_n = 1'b1;
      seen = 0;
      for (int i = 0; i < 50; i++) begin
         @(negedge clk);
         if (tick || ready) seen++;
      end
      check(seen == 0, "R1 disabled after reset", seen, 0);

      // R3 R4 R5 R6 R8 R9: table walk
      for (int v = 0; v < NVEC; v++) begin
         write_cfg(VEC_CFG[v]);
         check(tick == 1'b0 && ready == 1'b0, "R8 cleared by write", {tick, ready}, 0);
         wait_tick(VEC_RATIO[v] + 4, k, early);
         check(k == VEC_RATIO[v], "R3 R4 R9 first tick count", k, VEC_RATIO[v]);
         check(ready == 1'b1 && !early, "R8 ready rises with first tick", {early, ready}, 1);
         if (VEC_RATIO[v] > 1) begin
            @(negedge clk);
            check(tick == 1'b0, "R6 tick one cycle wide", tick, 0);
            wait_tick(VEC_RATIO[v] + 4, k2, early);
            k2 = k2 + 1;
         end else begin
            wait_tick(4, k2, early);
         end
         check(k2 == VEC_RATIO[v], "R5 period repeats", k2, VEC_RATIO[v]);
         check(ready == 1'b1, "R8 ready held", ready, 1);
      end

      // R2: disabled with other bits set
      write_cfg(8'h7F);
      seen = 0;
      for (int i = 0; i < 1000; i++) begin
         @(negedge clk);
         if (tick || ready) seen++;
      end
      check(seen == 0, "R2 no tick while disabled", seen, 0);

      // R7: rewrite in the middle of a period restarts counting
      write_cfg(8'h90);
      repeat (10) @(negedge clk);
      check(tick == 1'b0, "R7 no tick before period", tick, 0);
      write_cfg(8'h90);
      wait_tick(40, k, early);
      check(k == 16, "R7 restart after mid-period write", k, 16);
      check(!early, "R8 ready low until first tick", early, 0);

      // R7 R8: rewrite clears ready, new ratio takes effect
      write_cfg(8'h83);
      check(ready == 1'b0, "R8 ready cleared on rewrite", ready, 0);
      wait_tick(20, k, early);
      check(k == 7, "R7 new ratio after rewrite", k, 7);

      // R2: disabling write stops ticks and clears ready
      write_cfg(8'h03);
      seen = 0;
      for (int i = 0; i < 100; i++) begin
         @(negedge clk);
         if (tick || ready) seen++;
      end
      check(seen == 0, "R2 disable stops ticks", seen, 0);

      done = 1'b1;
      summary();
      $finish;
   end
endmodule